// File: doc/BRIEF.md
# Prescaled Timer with Compare Shortcuts

This block is an up-counter timer for a peripheral subsystem. A base tick, the block clock taken as 16 MHz, is divided by a power of two chosen through a prescaler register. Each divided tick adds one to the count while the timer is running. Other logic drives the timer through one-cycle strobes: start, stop, clear, and one capture strobe for each channel.

The timer has a set of capture/compare channels, four or six, fixed by a parameter. Each channel holds a compare value. When the count reaches that value, the channel's event flag is set and stays set. Each channel can also turn its own match into a counter clear, a counter stop, or both, without any help from software. This lets the timer measure a timeout and halt itself.

An interrupt line combines the events whose enables are set. A plain register port gives access to the prescaler, the shortcut enables, the event flags, the interrupt enables, the count and the compare values. Reads are combinational on the read address. Writes take effect at the clock edge on which write enable is high.

Top module: `ptm_timer`

## Requirements
- R1: The count increases by exactly one on each prescaled tick while running, and wraps from its all-ones value to 0.
- R2: Register 0 holds the prescaler. A tick occurs once every 2^P clock cycles while running, where P is the prescaler value. Written values above 9 are stored as 9. Reset value is 0.
- R3: The start strobe sets the timer running from the next cycle. The stop strobe halts it. Stop wins when both arrive together. The clear strobe sets the count to 0 and restarts the tick divider, and leaves the run state unchanged.
- R4: A clear strobe and a start strobe in the same cycle both take effect: the count becomes 0 and the timer runs.
- R5: The capture strobe of channel n copies the current count into that channel's compare value, which is read at address 16+n. A capture wins over a write to the same compare address in the same cycle.
- R6: A match of channel n sets bit n of the event register (address 2), and the bit stays set. Writing a 1 to bit n of address 2 clears it. A match in the same cycle as the clearing write keeps the bit set.
- R7: A match is detected only in the cycle after the count changed to equal the compare value. A count that stands still does not set the event again, and neither does writing a compare value equal to the current count.
- R8: Address 1 holds the shortcuts: bit n enables match-to-clear for channel n, and bit 8+n enables match-to-stop for channel n. In a match cycle, an enabled clear zeroes the count at the next edge and an enabled stop halts the timer.
- R9: Writing address 3 sets the interrupt enables whose bits are 1. Writing address 4 clears them. Both addresses read back the enable mask. The interrupt output is the OR over channels of event AND enable.
- R10: Address 5 reads the count and ignores writes. Unmapped addresses read 0.
- R11: After reset the timer is stopped, and the count, compare values, events, enables, shortcuts and prescaler are all 0.
- R12: A write to the prescaler register stops the timer, even when a start strobe arrives in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base tick clock (16 MHz) |
| rst_n | input | 1 | Synchronous active-low reset |
| task_start | input | 1 | Start strobe |
| task_stop | input | 1 | Stop strobe |
| task_clear | input | 1 | Clear strobe |
| task_capture | input | NUM_CH | Capture strobe, one per channel |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | DATA_W | Register read data, combinational |
| cnt_o | output | CNT_W | Current count |
| evt_o | output | NUM_CH | Sticky compare event flags |
| irq_o | output | 1 | Interrupt, OR of enabled events |

## Verification
The most likely internal faults each show at the ports within one or two cycles:
- A divider phase that is off by one shifts every later count step of cnt_o by whole cycles.
- A lost change flag either makes a stopped counter raise its event again, or loses a real match. Either way evt_o differs one cycle after the count settles.
- A wrongly mapped shortcut bit gives a wrong count period, or a counter that does not halt at its compare value. This is visible on cnt_o in the cycle after the match.

The bench models every register cycle by cycle and compares the count, the events, the interrupt and the read data in every cycle. A fault therefore shows at its first visible cycle and is not masked by later traffic.

// File: rtl/ptm_pkg.sv
// Shared constants of the prescaled timer: register addresses and fixed
// bit positions. Assumes a 5-bit word address space.
package ptm_pkg;
    localparam int ADDR_W      = 5;
    localparam int SC_STOP_LSB = 8;
    localparam logic [ADDR_W-1:0] ADR_PRESC = 5'd0;
    localparam logic [ADDR_W-1:0] ADR_SHORT = 5'd1;
    localparam logic [ADDR_W-1:0] ADR_EVENT = 5'd2;
    localparam logic [ADDR_W-1:0] ADR_IESET = 5'd3;
    localparam logic [ADDR_W-1:0] ADR_IECLR = 5'd4;
    localparam logic [ADDR_W-1:0] ADR_COUNT = 5'd5;
    localparam logic [ADDR_W-1:0] ADR_CMP0  = 5'd16;
endpackage

// File: rtl/ptm_prescale.sv
// Tick divider. While run is high it emits one tick every 2^ps cycles.
// It is held at phase 0 while stopped or when restart is high.
// Assumes ps never exceeds MAX_PS; the register stage saturates it.
module ptm_prescale #(
    parameter int MAX_PS = 9,
    parameter int PS_W   = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            restart,
    input  logic [PS_W-1:0] ps,
    output logic            tick
);
    localparam int DIV_W = (MAX_PS > 0) ? MAX_PS : 1;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] lim;

    // terminal phase for the selected power of two
    always_comb lim = DIV_W'((32'd1 << ps) - 32'd1);

    assign tick = run && (div_q == lim);

    // divider phase counter
    always_ff @(posedge clk) begin
        if (!rst_n || !run || restart) div_q <= '0;
        else if (div_q == lim)         div_q <= '0;
        else                           div_q <= div_q + DIV_W'(1);
    end
endmodule

// File: rtl/ptm_counter.sv
// Count register and run flag. halt has priority over go. zero has
// priority over tick. chg marks that the count changed at the last edge,
// which the compare channels need in order to detect a match once only.
module ptm_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             go,
    input  logic             halt,
    input  logic             zero,
    output logic [CNT_W-1:0] cnt,
    output logic             run,
    output logic             chg
);
    logic [CNT_W-1:0] cnt_d;

    // next count value
    always_comb begin
        if (zero)      cnt_d = '0;
        else if (tick) cnt_d = cnt + CNT_W'(1);
        else           cnt_d = cnt;
    end

    // count, change flag and run state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
            chg <= 1'b0;
            run <= 1'b0;
        end else begin
            cnt <= cnt_d;
            chg <= (cnt_d != cnt);
            if (halt)    run <= 1'b0;
            else if (go) run <= 1'b1;
        end
    end
endmodule

// File: rtl/ptm_channel.sv
// One capture/compare channel: compare register, match detect and sticky
// event. A capture wins over a register write. A match wins over an
// event clear.
module ptm_channel #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic             chg,
    input  logic             cap,
    input  logic             wr_cmp,
    input  logic [CNT_W-1:0] wr_val,
    input  logic             evt_clr,
    output logic [CNT_W-1:0] cmp,
    output logic             hit,
    output logic             evt
);
    assign hit = chg && (cnt == cmp);

    // compare value and event flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '0;
            evt <= 1'b0;
        end else begin
            if (cap)         cmp <= cnt;
            else if (wr_cmp) cmp <= wr_val;
            if (hit)          evt <= 1'b1;
            else if (evt_clr) evt <= 1'b0;
        end
    end
endmodule

// File: rtl/ptm_timer.sv
// Prescaled timer top. It decodes the register port, holds the prescaler,
// shortcut and interrupt-enable registers, and joins the channels'
// matches into internal clear and stop requests.
// Assumes DATA_W >= CNT_W, DATA_W >= 8 + NUM_CH and NUM_CH <= 8.
module ptm_timer
    import ptm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int NUM_CH = 4,
    parameter int DATA_W = 32,
    parameter int MAX_PS = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              task_start,
    input  logic              task_stop,
    input  logic              task_clear,
    input  logic [NUM_CH-1:0] task_capture,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [CNT_W-1:0]  cnt_o,
    output logic [NUM_CH-1:0] evt_o,
    output logic              irq_o
);
    localparam int PS_W = $clog2(MAX_PS + 1);

    logic [PS_W-1:0]   ps_q;
    logic [NUM_CH-1:0] sc_clr_q, sc_stop_q, ie_q;
    logic [NUM_CH-1:0] hit_v, evt_clr_v;
    logic [NUM_CH-1:0][CNT_W-1:0] cmp_v;
    logic              run_w, chg_w, tick_w, zero_w, halt_w;
    logic              wr_ps, wr_sc, wr_ev, wr_ies, wr_iec;

    assign wr_ps  = wr_en && (wr_addr == ADR_PRESC);
    assign wr_sc  = wr_en && (wr_addr == ADR_SHORT);
    assign wr_ev  = wr_en && (wr_addr == ADR_EVENT);
    assign wr_ies = wr_en && (wr_addr == ADR_IESET);
    assign wr_iec = wr_en && (wr_addr == ADR_IECLR);

    assign zero_w = task_clear || |(hit_v & sc_clr_q);
    assign halt_w = task_stop || |(hit_v & sc_stop_q) || wr_ps;

    // configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps_q      <= '0;
            sc_clr_q  <= '0;
            sc_stop_q <= '0;
            ie_q      <= '0;
        end else begin
            if (wr_ps)
                ps_q <= (wr_data > DATA_W'(MAX_PS)) ? PS_W'(MAX_PS) : wr_data[PS_W-1:0];
            if (wr_sc) begin
                sc_clr_q  <= wr_data[NUM_CH-1:0];
                sc_stop_q <= wr_data[SC_STOP_LSB +: NUM_CH];
            end
            ie_q <= (ie_q | (wr_ies ? wr_data[NUM_CH-1:0] : '0))
                  & ~(wr_iec ? wr_data[NUM_CH-1:0] : '0);
        end
    end

    ptm_prescale #(.MAX_PS(MAX_PS), .PS_W(PS_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run_w), .restart(zero_w),
        .ps(ps_q), .tick(tick_w)
    );

    ptm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_w), .go(task_start),
        .halt(halt_w), .zero(zero_w), .cnt(cnt_o), .run(run_w), .chg(chg_w)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        localparam logic [ADDR_W-1:0] CH_ADR = ADR_CMP0 + ADDR_W'(g);
        assign evt_clr_v[g] = wr_ev && wr_data[g];
        ptm_channel #(.CNT_W(CNT_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .cnt(cnt_o), .chg(chg_w),
            .cap(task_capture[g]),
            .wr_cmp(wr_en && (wr_addr == CH_ADR)),
            .wr_val(wr_data[CNT_W-1:0]), .evt_clr(evt_clr_v[g]),
            .cmp(cmp_v[g]), .hit(hit_v[g]), .evt(evt_o[g])
        );
    end

    assign irq_o = |(evt_o & ie_q);

    // register read multiplexer
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADR_PRESC: rd_data = DATA_W'(ps_q);
            ADR_SHORT: begin
                rd_data[NUM_CH-1:0]            = sc_clr_q;
                rd_data[SC_STOP_LSB +: NUM_CH] = sc_stop_q;
            end
            ADR_EVENT: rd_data = DATA_W'(evt_o);
            ADR_IESET, ADR_IECLR: rd_data = DATA_W'(ie_q);
            ADR_COUNT: rd_data = DATA_W'(cnt_o);
            default: ;
        endcase
        for (int i = 0; i < NUM_CH; i++)
            if (rd_addr == ADR_CMP0 + ADDR_W'(i)) rd_data = DATA_W'(cmp_v[i]);
    end
endmodule

// File: rtl/ptm_checker.sv
// Temporal checks on the prescaled timer. Attached by bind. Observes
// ports plus the run flag and the compare registers.
module ptm_checker
    import ptm_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int NUM_CH = 4
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         task_clear,
    input logic [NUM_CH-1:0]            task_capture,
    input logic                         wr_en,
    input logic [ADDR_W-1:0]            wr_addr,
    input logic [CNT_W-1:0]             cnt_o,
    input logic [NUM_CH-1:0]            evt_o,
    input logic                         irq_o,
    input logic                         running,
    input logic [NUM_CH-1:0][CNT_W-1:0] cmp_v
);
    // R11 reset clears count and flags
    a_r11_reset_state: assert property (@(posedge clk)
        !rst_n |=> (cnt_o == '0 && evt_o == '0 && !irq_o && !running));

    // R1 count moves by +1 or to zero
    a_r1_step_one: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_o != $past(cnt_o)) |->
            ((cnt_o - $past(cnt_o)) == CNT_W'(1) || cnt_o == '0));

    // R4 clear strobe zeroes the count next cycle
    a_r4_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        task_clear |=> (cnt_o == '0));

    // R6 events stay set without a clearing write
    a_r6_evt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == ADR_EVENT) |=>
            ((evt_o & $past(evt_o)) == $past(evt_o)));

    // R9 interrupt only with a pending event
    a_r9_irq_has_evt: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (evt_o != '0));

    // R12 prescaler write stops the timer
    a_r12_ps_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADR_PRESC) |=> !running);

    for (genvar g = 0; g < NUM_CH; g++) begin : g_cap
        // R5 capture copies the count
        a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
            task_capture[g] |=> (cmp_v[g] == $past(cnt_o)));
    end
endmodule

bind ptm_timer ptm_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .task_clear(task_clear),
    .task_capture(task_capture), .wr_en(wr_en), .wr_addr(wr_addr),
    .cnt_o(cnt_o), .evt_o(evt_o), .irq_o(irq_o), .running(run_w),
    .cmp_v(cmp_v)
);

// File: tb/ptm_timer_tb.sv
// Bench for the prescaled timer: a cycle model built from the requirements,
// compared with the ports every cycle, under directed and random stimulus.
module ptm_timer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW  = 10;
    localparam int NCH = 6;
    localparam int DW  = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic b_start = 0, b_stop = 0, b_clear = 0, b_wr = 0;
    logic [NCH-1:0] b_cap = '0;
    logic [4:0] b_waddr = '0, b_raddr = '0;
    logic [DW-1:0] b_wdata = '0;
    logic [DW-1:0] rd_data;
    logic [CW-1:0] cnt_o;
    logic [NCH-1:0] evt_o;
    logic irq_o;

    int n_chk = 0, n_bad = 0;
    string tag = "R11";
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ptm_timer #(.CNT_W(CW), .NUM_CH(NCH), .DATA_W(DW), .MAX_PS(9)) u_dut (
        .clk(clk), .rst_n(rst_n), .task_start(b_start), .task_stop(b_stop),
        .task_clear(b_clear), .task_capture(b_cap), .wr_en(b_wr),
        .wr_addr(b_waddr), .wr_data(b_wdata), .rd_addr(b_raddr),
        .rd_data(rd_data), .cnt_o(cnt_o), .evt_o(evt_o), .irq_o(irq_o)
    );

    // reference model state
    logic [CW-1:0] m_cnt;
    logic m_run, m_chg;
    logic [8:0] m_div;
    logic [3:0] m_ps;
    logic [NCH-1:0] m_scc, m_scs, m_evt, m_ie;
    logic [CW-1:0] m_cmp [NCH];
    logic [NCH-1:0] t_hit;
    logic t_zero, t_halt, t_tick, t_psw;
    logic [8:0] t_lim;
    logic [CW-1:0] t_nc;

    // model update at each edge, from the requirement text
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0; m_run <= 0; m_chg <= 0; m_div <= '0; m_ps <= '0;
            m_scc <= '0; m_scs <= '0; m_evt <= '0; m_ie <= '0;
            for (int i = 0; i < NCH; i++) m_cmp[i] <= '0;
        end else begin
            for (int i = 0; i < NCH; i++) t_hit[i] = m_chg && (m_cnt == m_cmp[i]);
            t_lim  = 9'((1 << m_ps) - 1);
            t_tick = m_run && (m_div == t_lim);
            t_psw  = b_wr && (b_waddr == 5'd0);
            t_zero = b_clear || |(t_hit & m_scc);
            t_halt = b_stop || |(t_hit & m_scs) || t_psw;
            t_nc   = t_zero ? '0 : (t_tick ? m_cnt + 1'b1 : m_cnt);
            m_div  <= (!m_run || t_zero || m_div == t_lim) ? '0 : m_div + 1'b1;
            m_cnt  <= t_nc;
            m_chg  <= (t_nc != m_cnt);
            m_run  <= t_halt ? 1'b0 : (b_start ? 1'b1 : m_run);
            for (int i = 0; i < NCH; i++) begin
                if (b_cap[i]) m_cmp[i] <= m_cnt;
                else if (b_wr && b_waddr == 5'(16 + i)) m_cmp[i] <= b_wdata[CW-1:0];
                if (t_hit[i]) m_evt[i] <= 1'b1;
                else if (b_wr && b_waddr == 5'd2 && b_wdata[i]) m_evt[i] <= 1'b0;
            end
            if (t_psw) m_ps <= (b_wdata > 9) ? 4'd9 : b_wdata[3:0];
            if (b_wr && b_waddr == 5'd1) begin
                m_scc <= b_wdata[NCH-1:0];
                m_scs <= b_wdata[8 +: NCH];
            end
            m_ie <= (m_ie | ((b_wr && b_waddr == 5'd3) ? b_wdata[NCH-1:0] : '0))
                  & ~((b_wr && b_waddr == 5'd4) ? b_wdata[NCH-1:0] : '0);
        end
    end

    function automatic logic [DW-1:0] m_read(input logic [4:0] a);
        logic [DW-1:0] r = '0;
        case (a)
            5'd0: r = DW'(m_ps);
            5'd1: begin r[NCH-1:0] = m_scc; r[8 +: NCH] = m_scs; end
            5'd2: r = DW'(m_evt);
            5'd3, 5'd4: r = DW'(m_ie);
            5'd5: r = DW'(m_cnt);
            default: ;
        endcase
        for (int i = 0; i < NCH; i++) if (a == 5'(16 + i)) r = DW'(m_cmp[i]);
        return r;
    endfunction

    task automatic chk(input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // one cycle: compare at the falling edge, then drop all strobes
    task automatic step();
        @(negedge clk);
        chk("count", DW'(cnt_o), DW'(m_cnt));
        chk("events", DW'(evt_o), DW'(m_evt));
        chk("irq", DW'(irq_o), DW'(|(m_evt & m_ie)));
        chk("rd_data", rd_data, m_read(b_raddr));
        b_start = 0; b_stop = 0; b_clear = 0; b_wr = 0; b_cap = '0;
    endtask

    task automatic idle(input int n);
        repeat (n) step();
    endtask

    task automatic reg_wr(input logic [4:0] a, input logic [DW-1:0] d);
        b_wr = 1; b_waddr = a; b_wdata = d; step();
    endtask

    function automatic logic [4:0] pick_addr(input int unsigned r);
        case (r % 10)
            0: return 5'd0;  1: return 5'd1;  2: return 5'd2;
            3: return 5'd3;  4: return 5'd4;  5: return 5'd5;
            6: return 5'd7;
            default: return 5'(16 + (r % NCH));
        endcase
    endfunction

    initial begin
        void'($urandom(32'd20211));
        tag = "R11"; b_raddr = 5'd1; idle(3);
        rst_n = 1; b_raddr = 5'd0; step();
        b_raddr = 5'd16; step();
        b_raddr = 5'd3; step();

        tag = "R3"; b_raddr = 5'd5;
        b_start = 1; idle(8);
        b_stop = 1; idle(4);
        b_start = 1; b_stop = 1; idle(3);
        b_start = 1; idle(5);
        b_clear = 1; idle(6);

        tag = "R4"; b_stop = 1; idle(3);
        b_clear = 1; b_start = 1; idle(6);

        tag = "R2"; reg_wr(5'd0, 2); b_start = 1; idle(25);
        reg_wr(5'd0, 12); b_raddr = 5'd0; step();
        b_start = 1; b_raddr = 5'd5; idle(40);

        tag = "R12"; b_start = 1; b_wr = 1; b_waddr = 5'd0; b_wdata = 0; step();
        idle(4);

        tag = "R5"; b_start = 1; idle(7);
        b_cap = 6'b000010; b_raddr = 5'd17; step();
        b_cap = 6'b000010; b_wr = 1; b_waddr = 5'd17; b_wdata = 5; idle(3);

        tag = "R8"; reg_wr(5'd16, 5); reg_wr(5'd1, 32'h1); b_clear = 1; idle(20);
        reg_wr(5'd1, 32'h0);
        tag = "R7"; reg_wr(5'd18, 40); reg_wr(5'd1, 32'h400); b_raddr = 5'd2;
        b_clear = 1; b_start = 1; idle(50);
        reg_wr(5'd2, 32'h3f); idle(10);
        reg_wr(5'd18, DW'(cnt_o)); idle(4);
        tag = "R9"; reg_wr(5'd3, 32'h4); b_raddr = 5'd3; idle(2);
        reg_wr(5'd18, 3); reg_wr(5'd1, 32'h0); b_start = 1; b_clear = 1; idle(10);
        reg_wr(5'd4, 32'h4); idle(2);
        reg_wr(5'd3, 32'h3f); idle(2);
        tag = "R6"; reg_wr(5'd2, 32'h3f); idle(3);

        tag = "R10"; reg_wr(5'd5, 32'h155); b_raddr = 5'd5; step();
        b_raddr = 5'd7; step(); b_raddr = 5'd31; step();

        tag = "R1"; reg_wr(5'd1, 0); b_start = 1; b_clear = 1; b_raddr = 5'd5;
        idle(1100);

        tag = "R6";
        for (int k = 0; k < 4000; k++) begin
            automatic int unsigned r = $urandom;
            b_start = (r[3:0] == 0);
            b_stop  = (r[7:4] == 0);
            b_clear = (r[11:8] == 0);
            b_cap   = (r[14:12] == 0) ? NCH'(1 << (r[18:15] % NCH)) : '0;
            if (r[21:19] == 0) begin
                b_wr = 1;
                b_waddr = pick_addr($urandom);
                b_wdata = (b_waddr == 5'd0) ? DW'($urandom % 12) :
                          (b_waddr >= 5'd16) ? DW'($urandom % 48) : $urandom;
            end
            b_raddr = pick_addr($urandom);
            step();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog %s: actual running expected finished", tag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule